// File: doc/BRIEF.md
# Effective Address Generation Unit

This unit sits between instruction decode and the load/store port of a processor datapath. Each request brings an addressing mode, an optional sub-mode bit and an operand size. It also brings the values of the base and index registers read from the register file, the address of the current instruction and a short signed displacement from the instruction word. One cycle later the unit presents the effective address to memory and a set of flags that tell the rest of the pipeline how to use that address. A mode that changes the base register also gets the new base value and a write enable for the register file.

The control path is a two-state machine. `ST_IDLE` means no result is being presented. `ST_RESULT` means the registered outputs hold the result of the request accepted on the previous edge. The machine has three transitions:

- `ST_IDLE` to `ST_RESULT` when `req_valid` is high.
- `ST_RESULT` to `ST_RESULT` when a new request arrives back to back.
- `ST_RESULT` to `ST_IDLE` when `req_valid` is low.

The displacement is sign-extended to the address width before any use. All address arithmetic wraps modulo 2^AW.

Top module: `eagu_top`

## Requirements
- R1: While `rst_n` is low, and after reset until the first request, `out_valid`, `ea`, `imm_flag`, `indirect_flag`, `wb_en` and `wb_val` are all zero.
- R2: A request sampled with `req_valid` high at a rising edge produces `out_valid` high for the cycle that follows. Where no request was sampled, `out_valid` is low.
- R3: Mode 0 (immediate): `imm_flag` is 1 and `ea` carries the sign-extended displacement as the operand value.
- R4: Mode 1 (register operand): `ea` is 0 and `imm_flag`, `indirect_flag` and `wb_en` are all 0.
- R5: Mode 2 (absolute): `ea` is the sign-extended displacement. With `sub_mode`=1 the mode is memory indirect: `ea` is the same, and `indirect_flag` is 1 to signal that the word read there holds the operand address.
- R6: Mode 3 (register indirect): `ea` = base. With `sub_mode`=1, `ea` = base + index.
- R7: Mode 4 (indexed): `ea` = base + sext(disp). With `sub_mode`=1, `ea` = base + index + sext(disp).
- R8: Mode 5 (PC-relative): `ea` = pc + sext(disp), so negative displacements reach addresses below pc.
- R9: Mode 6 (post-increment): `ea` = base (the old value), `wb_en` = 1, and `wb_val` = base + step.
- R10: Mode 7 (pre-decrement): `wb_val` = base − step, `ea` equals that new value, and `wb_en` = 1.
- R11: The step follows `op_size`: code 0 gives 1, code 1 gives 2, and codes 2 and 3 give 4.
- R12: `wb_en` is 1 only for modes 6 and 7. For every other mode `wb_en` and `wb_val` are 0.
- R13: The displacement is sign-extended by copying its top bit into all higher address bits. For example, 8'h80 becomes 16'hFF80 and 8'h7F becomes 16'h007F.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| mode | input | 3 | Addressing mode code 0..7 |
| sub_mode | input | 1 | Selects the memory-indirect variant (mode 2) or the base-plus-index variants (modes 3 and 4) |
| op_size | input | 2 | Operand size: 0 byte, 1 half word, 2 or 3 word |
| base_val | input | AW | Base register value |
| index_val | input | AW | Index register value |
| pc_val | input | AW | Program counter of the instruction |
| disp | input | DW | Signed displacement or immediate field |
| out_valid | output | 1 | Registered result present |
| ea | output | AW | Effective address, or the operand value in immediate mode |
| imm_flag | output | 1 | `ea` holds an operand value, not an address |
| indirect_flag | output | 1 | A second memory read is needed to obtain the operand address |
| wb_en | output | 1 | Base register write-back enable |
| wb_val | output | AW | New base register value |

## Verification
The address output and the base register update fall in the same cycle for the auto-update modes, so both come from one registered result. Post-increment must present the old base on `ea` while `wb_val` holds the stepped value. Pre-decrement must present the identical stepped value on both outputs. The sweep provokes this with every operand size and with base values at 0, 1, 16'h8000 and 16'hFFFF, which makes the step wrap through zero. For each vector the bench compares `ea`, `wb_val` and `wb_en` in that one cycle against values it computes itself.

// File: rtl/eagu_pkg.sv
package eagu_pkg;

    typedef enum logic [2:0] {
        AM_IMM     = 3'd0,
        AM_REG     = 3'd1,
        AM_ABS     = 3'd2,
        AM_RIND    = 3'd3,
        AM_IDX     = 3'd4,
        AM_PCREL   = 3'd5,
        AM_POSTINC = 3'd6,
        AM_PREDEC  = 3'd7
    } amode_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_WIDE = 2'd3
    } osize_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_RESULT = 1'b1
    } est_e;

endpackage

// File: rtl/eagu_sext.sv
module eagu_sext #(
    parameter int IW = 8,
    parameter int OW = 16
) (
    input  logic [IW-1:0] din,
    output logic [OW-1:0] dout
);
    localparam int PAD = (OW > IW) ? (OW - IW) : 0;

    generate
        if (PAD > 0) begin : g_widen
            assign dout = {{PAD{din[IW-1]}}, din};
        end else begin : g_trunc
            assign dout = din[OW-1:0];
        end
    endgenerate
endmodule

// File: rtl/eagu_step.sv
module eagu_step #(
    parameter int AW = 16
) (
    input  logic [1:0]    size,
    output logic [AW-1:0] step
);
    import eagu_pkg::*;

    always_comb begin
        unique case (osize_e'(size))
            SZ_BYTE: step = AW'(1);
            SZ_HALF: step = AW'(2);
            SZ_WORD: step = AW'(4);
            SZ_WIDE: step = AW'(4);
            default: step = AW'(4);
        endcase
    end
endmodule

// File: rtl/eagu_core.sv
module eagu_core #(
    parameter int AW = 16
) (
    input  logic [2:0]    mode,
    input  logic          sub_mode,
    input  logic [AW-1:0] base_val,
    input  logic [AW-1:0] index_val,
    input  logic [AW-1:0] pc_val,
    input  logic [AW-1:0] dext,
    input  logic [AW-1:0] step,
    output logic [AW-1:0] ea,
    output logic          imm,
    output logic          ind,
    output logic          wb_en,
    output logic [AW-1:0] wb_val
);
    import eagu_pkg::*;

    logic [AW-1:0] base_idx;
    logic [AW-1:0] idx_off;
    logic [AW-1:0] dec_val;

    assign base_idx = base_val + index_val;
    assign idx_off  = (sub_mode ? base_idx : base_val) + dext;
    assign dec_val  = base_val - step;

    always_comb begin
        ea     = '0;
        imm    = 1'b0;
        ind    = 1'b0;
        wb_en  = 1'b0;
        wb_val = '0;
        unique case (amode_e'(mode))
            AM_IMM: begin
                ea  = dext;
                imm = 1'b1;
            end
            AM_REG: begin
                ea = '0;
            end
            AM_ABS: begin
                ea  = dext;
                ind = sub_mode;
            end
            AM_RIND: begin
                ea = sub_mode ? base_idx : base_val;
            end
            AM_IDX: begin
                ea = idx_off;
            end
            AM_PCREL: begin
                ea = pc_val + dext;
            end
            AM_POSTINC: begin
                ea     = base_val;
                wb_en  = 1'b1;
                wb_val = base_val + step;
            end
            AM_PREDEC: begin
                ea     = dec_val;
                wb_en  = 1'b1;
                wb_val = dec_val;
            end
            default: begin
                ea = '0;
            end
        endcase
    end
endmodule

// File: rtl/eagu_top.sv
module eagu_top #(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [2:0]    mode,
    input  logic          sub_mode,
    input  logic [1:0]    op_size,
    input  logic [AW-1:0] base_val,
    input  logic [AW-1:0] index_val,
    input  logic [AW-1:0] pc_val,
    input  logic [DW-1:0] disp,
    output logic          out_valid,
    output logic [AW-1:0] ea,
    output logic          imm_flag,
    output logic          indirect_flag,
    output logic          wb_en,
    output logic [AW-1:0] wb_val
);
    import eagu_pkg::*;

    logic [AW-1:0] dext;
    logic [AW-1:0] step;
    logic [AW-1:0] c_ea;
    logic [AW-1:0] c_wb_val;
    logic          c_imm;
    logic          c_ind;
    logic          c_wb_en;

    est_e state_q;
    est_e state_d;

    eagu_sext #(.IW(DW), .OW(AW)) u_sext (
        .din  (disp),
        .dout (dext)
    );

    eagu_step #(.AW(AW)) u_step (
        .size (op_size),
        .step (step)
    );

    eagu_core #(.AW(AW)) u_core (
        .mode      (mode),
        .sub_mode  (sub_mode),
        .base_val  (base_val),
        .index_val (index_val),
        .pc_val    (pc_val),
        .dext      (dext),
        .step      (step),
        .ea        (c_ea),
        .imm       (c_imm),
        .ind       (c_ind),
        .wb_en     (c_wb_en),
        .wb_val    (c_wb_val)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   state_d = req_valid ? ST_RESULT : ST_IDLE;
            ST_RESULT: state_d = req_valid ? ST_RESULT : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n || !req_valid) begin
            ea            <= '0;
            imm_flag      <= 1'b0;
            indirect_flag <= 1'b0;
            wb_en         <= 1'b0;
            wb_val        <= '0;
        end else begin
            ea            <= c_ea;
            imm_flag      <= c_imm;
            indirect_flag <= c_ind;
            wb_en         <= c_wb_en;
            wb_val        <= c_wb_val;
        end
    end

    assign out_valid = (state_q == ST_RESULT);

    // Assertions
    AST_VALID_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> out_valid); // R2
    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !out_valid); // R2
    AST_IMM_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && mode == 3'd0) |=> imm_flag); // R3
    AST_WB_AUTO_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && mode != 3'd6 && mode != 3'd7) |=> !wb_en); // R12
    AST_WB_AUTO_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && mode[2:1] == 2'b11) |=> wb_en); // R12
    AST_POSTINC_OLD: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && mode == 3'd6) |=> ea == $past(base_val)); // R9
    AST_PREDEC_SAME: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && mode == 3'd7) |=> ea == wb_val); // R10
    AST_BYTE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && mode == 3'd6 && op_size == 2'd0) |=> wb_val == ea + AW'(1)); // R11
    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({imm_flag, indirect_flag, wb_en})); // R4
endmodule

// File: tb/sim_eagu_top.sv
module sim_eagu_top;
    localparam int AW = 16;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [2:0]    mode = '0;
    logic          sub_mode = 1'b0;
    logic [1:0]    op_size = '0;
    logic [AW-1:0] base_val = '0;
    logic [AW-1:0] index_val = '0;
    logic [AW-1:0] pc_val = '0;
    logic [DW-1:0] disp = '0;
    logic          out_valid;
    logic [AW-1:0] ea;
    logic          imm_flag;
    logic          indirect_flag;
    logic          wb_en;
    logic [AW-1:0] wb_val;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    eagu_top #(.AW(AW), .DW(DW)) u0 (
        .clk, .rst_n, .req_valid, .mode, .sub_mode, .op_size,
        .base_val, .index_val, .pc_val, .disp,
        .out_valid, .ea, .imm_flag, .indirect_flag, .wb_en, .wb_val
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] sx(input logic [DW-1:0] d);
        return {{(AW-DW){d[DW-1]}}, d};
    endfunction

    function automatic logic [AW-1:0] stp(input logic [1:0] z);
        return (z == 2'd0) ? 16'd1 : (z == 2'd1) ? 16'd2 : 16'd4;
    endfunction

    task automatic run_vec(input logic [2:0] m, input logic s, input logic [1:0] z,
                           input logic [AW-1:0] b, input logic [AW-1:0] x,
                           input logic [AW-1:0] p, input logic [DW-1:0] d);
        logic [AW-1:0] e_ea, e_wb;
        logic e_imm, e_ind, e_wen;
        string tag;
        e_ea = '0; e_wb = '0; e_imm = 0; e_ind = 0; e_wen = 0;
        case (m)
            3'd0: begin e_ea = sx(d); e_imm = 1; tag = "R3"; end
            3'd1: begin tag = "R4"; end
            3'd2: begin e_ea = sx(d); e_ind = s; tag = "R5"; end
            3'd3: begin e_ea = s ? b + x : b; tag = "R6"; end
            3'd4: begin e_ea = (s ? b + x : b) + sx(d); tag = "R7"; end
            3'd5: begin e_ea = p + sx(d); tag = "R8"; end
            3'd6: begin e_ea = b; e_wb = b + stp(z); e_wen = 1; tag = "R9 R11"; end
            default: begin e_wb = b - stp(z); e_ea = e_wb; e_wen = 1; tag = "R10 R11"; end
        endcase
        @(negedge clk);
        req_valid = 1; mode = m; sub_mode = s; op_size = z;
        base_val = b; index_val = x; pc_val = p; disp = d;
        @(negedge clk);
        req_valid = 0;
        check("R2 valid", 32'(out_valid), 32'd1);
        check({tag, " ea"}, 32'(ea), 32'(e_ea));
        check({tag, " imm"}, 32'(imm_flag), 32'(e_imm));
        check({tag, " ind"}, 32'(indirect_flag), 32'(e_ind));
        check("R12 wb_en", 32'(wb_en), 32'(e_wen));
        check("R12 wb_val", 32'(wb_val), 32'(e_wb));
    endtask

    initial begin
        logic [AW-1:0] bc [4];
        logic [DW-1:0] dc [4];
        bc[0] = 16'h0000; bc[1] = 16'hFFFF; bc[2] = 16'h8000; bc[3] = 16'h0001;
        dc[0] = 8'h80; dc[1] = 8'h7F; dc[2] = 8'hFF; dc[3] = 8'h00;
        repeat (3) @(negedge clk);
        check("R1 reset valid", 32'(out_valid), 32'd0);
        check("R1 reset ea", 32'(ea), 32'd0);
        check("R1 reset wb", 32'({wb_en, wb_val}), 32'd0);
        rst_n = 1;
        @(negedge clk);
        check("R1 idle valid", 32'(out_valid), 32'd0);
        check("R1 idle flags", 32'({imm_flag, indirect_flag, wb_en}), 32'd0);
        for (int m = 0; m < 8; m++)
            for (int s = 0; s < 2; s++)
                for (int z = 0; z < 4; z++)
                    for (int k = 0; k < 12; k++) begin
                        logic [AW-1:0] b, x, p;
                        logic [DW-1:0] d;
                        b = (k < 4) ? bc[k] : 16'($urandom);
                        d = (k < 4) ? dc[k] : 8'($urandom);
                        x = 16'($urandom); p = 16'($urandom);
                        run_vec(3'(m), 1'(s), 2'(z), b, x, p, d);
                    end
        // R13: every displacement through immediate and PC-relative
        for (int d = 0; d < 256; d++) begin
            run_vec(3'd0, 1'b0, 2'd0, 16'h0, 16'h0, 16'h0, 8'(d));
            run_vec(3'd5, 1'b0, 2'd0, 16'h0, 16'h0, 16'h1000, 8'(d));
        end
        @(negedge clk);
        check("R13 sext 80", 32'(sx(8'h80)), 32'h0000FF80);
        // R2: back-to-back then idle
        @(negedge clk);
        req_valid = 1; mode = 3'd3; sub_mode = 0; base_val = 16'h1234;
        @(negedge clk);
        base_val = 16'h4321;
        check("R2 b2b first", 32'(ea), 32'h1234);
        @(negedge clk);
        req_valid = 0;
        check("R2 b2b second", 32'(ea), 32'h4321);
        check("R2 b2b valid", 32'(out_valid), 32'd1);
        @(negedge clk);
        check("R2 drop valid", 32'(out_valid), 32'd0);
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #(10 * 150000);
        if (!done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule